// File: doc/BRIEF.md
# Multiplexed-Bus Read Cycle Sequencer

This block runs the bus side of the read machine cycles for a small 8-bit processor. The processor has a 16-bit address, and its low address byte shares one set of lines with the data byte. A single-cycle request starts the block. The request gives a cycle kind and an address. The block then walks through a fixed series of T-states and drives the high address byte, the shared low lines, the address strobe, the active-low read strobe and three status lines. It samples the byte that the addressed device returns. It then ends the cycle with a one-clock done pulse.

Each T-state takes two clocks of the block's clock. The first clock is the first half of the T-state and the second clock is the second half. This lets the address strobe rise for the first half of T1 only. An external latch can then hold the low address byte before the shared lines go over to data. An opcode fetch takes four T-states: T1, T2, T3 and a quiet decode state T4. It loads the fetched byte into an instruction register. A memory read or port read takes three T-states: T1, T2 and T3. For a port read, the 8-bit port number appears on both the high and the low address lines.

The state machine has five states: IDLE, T1, T2, T3 and T4. A half flag runs beside the state. The transitions are as follows. IDLE goes to T1 on an accepted request. Each T-state steps from its first half to its second half. T1 goes to T2 and T2 goes to T3. At the end of T3, a fetch goes to T4 and a read goes to IDLE. T4 goes to IDLE.

Top module: `mxrd_seqr`

## Requirements
- R1: Out of reset, and whenever no cycle runs, the outputs are as follows: `busy`=0, `done`=0, `ale`=0, `ad_oe`=0, `rd_n`=1, status {`io_m`,`s1`,`s0`}=000 and `addr_hi`=0.
- R2: A request (`req_valid`=1 at a clock edge) is taken only while `busy`=0. A request made while a cycle runs does not change the running cycle's address or status. It also does not start a cycle after that cycle ends.
- R3: An opcode fetch keeps `busy` high for 8 clocks and a memory or port read for 6 clocks, starting with the clock after the accepting edge. `done` is high only in the last of those clocks, and `busy` is low in the clock after it.
- R4: During T1 (clocks 1 and 2 of the cycle), `addr_hi` carries address bits 15:8, and `ad_out` carries bits 7:0 with `ad_oe`=1. For a port read, both carry the port number, which is `req_addr[7:0]`. `addr_hi` holds its value until the cycle ends.
- R5: `ale` is high in clock 1 of the cycle only, which is the first half of T1.
- R6: `rd_n` is low in clocks 3, 4 and 5, which are T2 and the first half of T3, and high in every other clock. `ad_oe` is 0 from clock 3 onward.
- R7: The byte on `ad_in` at the clock edge that ends clock 5 is captured. It appears on `rdata` from clock 6 and stays there until the next capture.
- R8: An opcode fetch loads the captured byte into `ir`, and a memory or port read leaves `ir` unchanged. In T4 (clocks 7 and 8 of a fetch) there is no bus activity: `rd_n`=1, `ale`=0 and `ad_oe`=0.
- R9: `req_kind` 0 is an opcode fetch with status {`io_m`,`s1`,`s0`}=011. Kind 1 is a memory read with status 010. Kind 2 is a port read with status 110. The status stays the same for the whole cycle.
- R10: `req_kind` 3 is reserved. A request with it starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two per T-state |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Cycle kind: 0 fetch, 1 memory read, 2 port read, 3 reserved |
| req_addr | input | 16 | Address, or port number in bits 7:0 |
| busy | output | 1 | A cycle is running |
| addr_hi | output | 8 | High address lines |
| ad_out | output | 8 | Value driven on the shared low address/data lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_in | input | 8 | Value read from the shared lines |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| io_m | output | 1 | Status: port space when 1 |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| done | output | 1 | One-clock end-of-cycle pulse |
| rdata | output | 8 | Last captured byte |
| ir | output | 8 | Instruction register |

## Verification
The outputs are decoded from the state and the half flag in every clock, with no extra register in between. A wrong state or a wrong half value therefore shows at the pins in the same clock. It appears as a misplaced `ale`, an early or late `rd_n` edge, or a `done` pulse at the wrong count. A wrong latched kind shows at once on the status lines. It also shows by the end of T3, when a read runs on into T4 or a fetch stops short. A capture taken at the wrong edge shows on `rdata` one clock later, because the bench changes `ad_in` straight after the intended sampling edge.

// File: rtl/mxrd_pkg.sv
package mxrd_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_MEMRD = 2'd1,
        KIND_IORD  = 2'd2,
        KIND_RSVD  = 2'd3
    } cyc_kind_t;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } tstate_t;

    typedef struct packed {
        logic io_m;
        logic s1;
        logic s0;
    } bus_status_t;

    localparam bus_status_t STATUS_IDLE = '{io_m: 1'b0, s1: 1'b0, s0: 1'b0};

    function automatic bus_status_t kind_status(input cyc_kind_t k);
        bus_status_t s;
        unique case (k)
            KIND_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
            KIND_MEMRD: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
            KIND_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
            default:    s = STATUS_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mxrd_tstep.sv
module mxrd_tstep
    import mxrd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    fetch_q,
    output tstate_t tst,
    output logic    half,
    output logic    capture,
    output logic    last
);

    tstate_t tst_d;
    logic    half_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst  <= ST_IDLE;
            half <= 1'b0;
        end else begin
            tst  <= tst_d;
            half <= half_d;
        end
    end

    always_comb begin
        tst_d  = tst;
        half_d = half;
        unique case (tst)
            ST_IDLE: begin
                half_d = 1'b0;
                if (start) tst_d = ST_T1;
            end
            ST_T1: begin
                if (!half) half_d = 1'b1;
                else begin
                    tst_d  = ST_T2;
                    half_d = 1'b0;
                end
            end
            ST_T2: begin
                if (!half) half_d = 1'b1;
                else begin
                    tst_d  = ST_T3;
                    half_d = 1'b0;
                end
            end
            ST_T3: begin
                if (!half) half_d = 1'b1;
                else begin
                    tst_d  = fetch_q ? ST_T4 : ST_IDLE;
                    half_d = 1'b0;
                end
            end
            ST_T4: begin
                if (!half) half_d = 1'b1;
                else begin
                    tst_d  = ST_IDLE;
                    half_d = 1'b0;
                end
            end
            default: begin
                tst_d  = ST_IDLE;
                half_d = 1'b0;
            end
        endcase
    end

    always_comb begin
        capture = (tst == ST_T3) && !half;
        last    = half && (((tst == ST_T3) && !fetch_q) || (tst == ST_T4));
    end

endmodule

// File: rtl/mxrd_hold.sv
module mxrd_hold
    import mxrd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cyc_kind_t         kind_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              capture,
    input  logic [DATA_W-1:0] ad_in,
    output cyc_kind_t         kind_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] ir_q
);

    logic [ADDR_W-1:0] addr_eff;

    always_comb begin
        if (kind_in == KIND_IORD)
            addr_eff = {addr_in[DATA_W-1:0], addr_in[DATA_W-1:0]};
        else
            addr_eff = addr_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= KIND_FETCH;
            addr_q <= '0;
            data_q <= '0;
            ir_q   <= '0;
        end else begin
            if (start) begin
                kind_q <= kind_in;
                addr_q <= addr_eff;
            end
            if (capture) begin
                data_q <= ad_in;
                if (kind_q == KIND_FETCH) ir_q <= ad_in;
            end
        end
    end

endmodule

// File: rtl/mxrd_pins.sv
module mxrd_pins
    import mxrd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  tstate_t           tst,
    input  logic              half,
    input  logic              last,
    input  cyc_kind_t         kind_q,
    input  logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_n,
    output bus_status_t       status,
    output logic              done
);

    always_comb begin
        addr_hi = '0;
        ad_out  = '0;
        ad_oe   = 1'b0;
        ale     = 1'b0;
        rd_n    = 1'b1;
        status  = STATUS_IDLE;
        done    = 1'b0;
        unique case (tst)
            ST_IDLE: begin
            end
            ST_T1: begin
                addr_hi = addr_q[ADDR_W-1:DATA_W];
                ad_out  = addr_q[DATA_W-1:0];
                ad_oe   = 1'b1;
                ale     = !half;
                status  = kind_status(kind_q);
            end
            ST_T2: begin
                addr_hi = addr_q[ADDR_W-1:DATA_W];
                rd_n    = 1'b0;
                status  = kind_status(kind_q);
            end
            ST_T3: begin
                addr_hi = addr_q[ADDR_W-1:DATA_W];
                rd_n    = half;
                status  = kind_status(kind_q);
                done    = last;
            end
            ST_T4: begin
                addr_hi = addr_q[ADDR_W-1:DATA_W];
                status  = kind_status(kind_q);
                done    = last;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/mxrd_seqr.sv
module mxrd_seqr
    import mxrd_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic [DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              rd_n,
    output logic              io_m,
    output logic              s1,
    output logic              s0,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] ir
);

    tstate_t     tst;
    logic        half;
    logic        capture;
    logic        last;
    logic        start;
    cyc_kind_t   kind_in;
    cyc_kind_t   kind_q;
    logic [ADDR_W-1:0] addr_q;
    bus_status_t status;

    always_comb begin
        kind_in = cyc_kind_t'(req_kind);
        start   = (tst == ST_IDLE) && req_valid && (kind_in != KIND_RSVD);
        busy    = (tst != ST_IDLE);
        io_m    = status.io_m;
        s1      = status.s1;
        s0      = status.s0;
    end

    mxrd_tstep u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .fetch_q (kind_q == KIND_FETCH),
        .tst     (tst),
        .half    (half),
        .capture (capture),
        .last    (last)
    );

    mxrd_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .kind_in (kind_in),
        .addr_in (req_addr),
        .capture (capture),
        .ad_in   (ad_in),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .data_q  (rdata),
        .ir_q    (ir)
    );

    mxrd_pins #(.DATA_W(DATA_W)) u_pins (
        .tst     (tst),
        .half    (half),
        .last    (last),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .addr_hi (addr_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .status  (status),
        .done    (done)
    );

endmodule

// File: rtl/mxrd_chk.sv
module mxrd_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              ale,
    input logic              rd_n,
    input logic              ad_oe,
    input logic              io_m,
    input logic              s1,
    input logic              s0,
    input logic [DATA_W-1:0] addr_hi
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (rd_n && !ale && !ad_oe && !done && !io_m && !s1 && !s0)); // R1

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(rst_n)) |-> $stable(addr_hi)); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3

    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3

    AST_ALE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R5

    AST_ALE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n)); // R5

    AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe); // R6

    AST_STATUS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(rst_n)) |-> $stable({io_m, s1, s0})); // R9

    AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> s1); // R9

endmodule

bind mxrd_seqr mxrd_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .ale     (ale),
    .rd_n    (rd_n),
    .ad_oe   (ad_oe),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .addr_hi (addr_hi)
);

// File: tb/sim_mxrd_seqr.sv
module sim_mxrd_seqr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  ad_in = 8'h0;
    logic        busy, ad_oe, ale, rd_n, io_m, s1, s0, done;
    logic [7:0]  addr_hi, ad_out, rdata, ir;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;
    logic [7:0] exp_ir = 8'h0;
    logic [7:0] exp_rd = 8'h0;

    always #4 clk = ~clk;

    mxrd_seqr u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .busy(busy), .addr_hi(addr_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .rd_n(rd_n), .io_m(io_m),
        .s1(s1), .s0(s0), .done(done), .rdata(rdata), .ir(ir)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " busy"}, busy, 0);
        chk({tag, " done"}, done, 0);
        chk({tag, " ale"}, ale, 0);
        chk({tag, " ad_oe"}, ad_oe, 0);
        chk({tag, " rd_n"}, rd_n, 1);
        chk({tag, " status"}, {io_m, s1, s0}, 3'b000);
        chk({tag, " addr_hi"}, addr_hi, 0);
    endtask

    task automatic run_cycle(input logic [1:0] kind, input logic [15:0] addr,
                             input logic [7:0] data, input bit interfere);
        int n;
        logic [7:0] ehi, elo;
        logic [2:0] est;
        n   = (kind == 2'd0) ? 8 : 6;
        ehi = (kind == 2'd2) ? addr[7:0] : addr[15:8];
        elo = addr[7:0];
        est = (kind == 2'd0) ? 3'b011 : (kind == 2'd1) ? 3'b010 : 3'b110;
        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = addr;
        ad_in     = ~data;
        @(posedge clk);
        for (int p = 0; p < n; p++) begin
            @(negedge clk);
            if (p == 0) req_valid = 1'b0;
            chk("R3 busy", busy, 1);
            chk("R3 done", done, (p == n - 1));
            chk("R5 ale", ale, (p == 0));
            chk("R6 rd_n", rd_n, !(p >= 2 && p <= 4));
            chk("R4 ad_oe", ad_oe, (p <= 1));
            if (p <= 1) chk("R4 ad_out", ad_out, elo);
            chk("R4 R2 addr_hi", addr_hi, ehi);
            chk("R9 status", {io_m, s1, s0}, est);
            if (p >= 6) chk("R8 T4 quiet", {rd_n, ale, ad_oe}, 3'b100);
            if (p == n - 1) chk("R7 rdata", rdata, data);
            if (p == 2) ad_in = data;
            if (p == 5) begin
                chk("R7 rdata after capture", rdata, data);
                ad_in = ~data;
            end
            if (interfere && p == 3) begin
                req_valid = 1'b1;
                req_kind  = 2'd1;
                req_addr  = ~addr;
            end
            if (interfere && p == 4) req_valid = 1'b0;
        end
        if (kind == 2'd0) exp_ir = data;
        exp_rd = data;
        @(negedge clk);
        chk_idle("R3 after cycle");
        chk("R8 ir", ir, exp_ir);
        chk("R7 rdata held", rdata, exp_rd);
        if (interfere) begin
            @(negedge clk);
            chk("R2 no late start", busy, 0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after reset");
        chk("R1 ir", ir, 0);
        chk("R1 rdata", rdata, 0);

        // R10: reserved kind starts nothing
        req_valid = 1'b1;
        req_kind  = 2'd3;
        req_addr  = 16'hBEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk_idle("R10 reserved");
        @(negedge clk);
        chk("R10 still idle", busy, 0);

        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 6; i++) begin
                logic [15:0] a;
                logic [7:0]  d;
                a = (16'h1F3B * 16'(i + 1)) ^ (16'(k) << 14);
                d = 8'h5A + 8'(i * 37) + 8'(k * 11);
                run_cycle(2'(k), a, d, (i == 2));
            end
        end
        // R8: read after fetch keeps ir
        run_cycle(2'd0, 16'h0000, 8'hFF, 1'b0);
        run_cycle(2'd1, 16'hFFFF, 8'h00, 1'b0);
        run_cycle(2'd2, 16'h12A5, 8'h3C, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule